// File: doc/BRIEF.md
# Indirect Device Register Access Bridge

This block sits behind a PHY management interface and opens a window into a larger register space that the 32-entry, 5-bit management address map cannot reach directly. Two management registers carry the mechanism. The control register at address 13 selects one of 32 target devices and an access function. The window register at address 14 either holds the address pointer of the selected device or passes data to and from that device's 16-bit register space.

One 16-bit pointer is kept for each device address, so software can switch devices and come back without reloading a pointer. In data mode each window access is forwarded to a simple internal port: an address, a device number, write data and read data, with one read or write strobe. Depending on the function, the pointer then stays put, advances after every access, or advances after writes only. The serial framing of the management bus and the contents of the device registers are handled elsewhere.

Top module: `mmd_window_bridge`

## Requirements
- R1: After reset the control register reads 0x0000 and the pointer of every device reads 0x0000.
- R2: Control register (address 13): bits 15:14 hold the function code and bits 4:0 hold the device number. Bits 13:5 read as zero and writes to them are ignored. A new value takes effect from the next cycle.
- R3: With function code 0, a write to address 14 loads the selected device's pointer and a read of address 14 returns it. No internal strobe is raised.
- R4: Each of the 32 devices has its own pointer. Loading or advancing one pointer leaves the other pointers unchanged.
- R5: With function codes 1, 2 or 3, an access to address 14 drives the internal port with the selected device and its current pointer. A write forwards the management write data. A read returns the internal read data. With code 1 the pointer is not changed.
- R6: With function code 2 the pointer advances by one after every data read and every data write.
- R7: With function code 3 the pointer advances by one after a data write and is unchanged after a data read.
- R8: A pointer advancing from 0xFFFF becomes 0x0000.
- R9: A data-mode access raises exactly one internal strobe (write or read), in the same cycle as the management access. No strobe is raised at any other time. A pointer advance is visible from the following cycle.
- R10: Reads of any address other than 13 and 14 return 0x0000. Writes to them change no register and raise no strobe.
- R11: Read data appears on the management read port in the cycle after the read and is held until the next read. If read and write are asserted together, only the write is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mg_addr | input | 5 | Management register address |
| mg_wr | input | 1 | Management write, one cycle |
| mg_rd | input | 1 | Management read, one cycle |
| mg_wdata | input | 16 | Management write data |
| mg_rdata | output | 16 | Registered management read data |
| dev_addr | output | 16 | Internal port register address (current pointer) |
| dev_sel | output | 5 | Internal port device number |
| dev_wdata | output | 16 | Internal port write data |
| dev_wr | output | 1 | Internal port write strobe |
| dev_rd | output | 1 | Internal port read strobe |
| dev_rdata | input | 16 | Internal port read data, valid in the strobe cycle |

## Verification
Random sequences mix control writes, pointer loads, data reads and writes under all four function codes, and stray accesses to other addresses. A bench model follows every pointer, so a wrong increment policy shows up as a wrong address on the internal port or as a wrong pointer read-back. Directed cases cover three things. A pointer load at 0xFFFF followed by an advancing access catches a missing wrap. A sweep of all 32 devices, each loaded with its own value, catches pointers that share storage. Read and write asserted together catch a write that does not take priority. The internal read data is a function of address and device, so a read forwarded to the wrong location returns the wrong value.

// File: rtl/mmd_window_pkg.sv
package mmd_window_pkg;
  typedef enum logic [1:0] {
    FN_PTR       = 2'd0,
    FN_DATA      = 2'd1,
    FN_DATA_INC  = 2'd2,
    FN_DATA_INCW = 2'd3
  } win_fn_e;

  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_CTRL = 2'd1,
    SRC_PTR  = 2'd2,
    SRC_DEV  = 2'd3
  } rd_src_e;
endpackage

// File: rtl/mmd_ctrl_reg.sv
module mmd_ctrl_reg
  import mmd_window_pkg::*;
#(
  parameter int DEV_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        fn_in,
  input  logic [DEV_AW-1:0] dev_in,
  output win_fn_e           fn_q,
  output logic [DEV_AW-1:0] dev_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fn_q  <= FN_PTR;
      dev_q <= '0;
    end else if (we) begin
      fn_q  <= win_fn_e'(fn_in);
      dev_q <= dev_in;
    end
  end

  a_r2_hold_without_write: assert property (@(posedge clk) disable iff (rst)
    !we |=> ($stable(fn_q) && $stable(dev_q)));
endmodule

// File: rtl/mmd_ptr_file.sv
module mmd_ptr_file #(
  parameter int DEV_AW = 5,
  parameter int PTR_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DEV_AW-1:0] idx,
  input  logic              load,
  input  logic [PTR_W-1:0]  load_val,
  input  logic              inc,
  output logic [PTR_W-1:0]  cur
);
  localparam int NDEV = 1 << DEV_AW;

  logic [PTR_W-1:0] mem [NDEV];
  logic [NDEV-1:0]  valid;
  logic             wen;
  logic [PTR_W-1:0] wval;

  assign cur  = valid[idx] ? mem[idx] : '0;
  assign wen  = load || inc;
  assign wval = load ? load_val : cur + PTR_W'(1);

  always_ff @(posedge clk) begin
    if (wen) mem[idx] <= wval;
  end

  always_ff @(posedge clk) begin
    if (rst)      valid      <= '0;
    else if (wen) valid[idx] <= 1'b1;
  end

  // R6 R8: an advance adds one modulo 2^PTR_W, visible next cycle
  a_r8_advance_wraps: assert property (@(posedge clk) disable iff (rst)
    (inc && !load) |=> (!$stable(idx) || cur == PTR_W'($past(cur) + PTR_W'(1))));

  a_r3_load_visible: assert property (@(posedge clk) disable iff (rst)
    load |=> (!$stable(idx) || cur == $past(load_val)));
endmodule

// File: rtl/mmd_win_decode.sv
module mmd_win_decode
  import mmd_window_pkg::*;
#(
  parameter int REG_AW    = 5,
  parameter int CTRL_ADDR = 13,
  parameter int WIN_ADDR  = 14
) (
  input  logic [REG_AW-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  win_fn_e           fn,
  output logic              ctrl_we,
  output logic              ptr_load,
  output logic              ptr_inc,
  output logic              strobe_wr,
  output logic              strobe_rd,
  output logic              rd_take,
  output rd_src_e           rd_src
);
  logic hit_ctrl, hit_win, data_mode, rd_op;

  always_comb begin
    hit_ctrl  = (addr == REG_AW'(CTRL_ADDR));
    hit_win   = (addr == REG_AW'(WIN_ADDR));
    data_mode = (fn != FN_PTR);
    rd_op     = rd && !wr;

    ctrl_we   = wr && hit_ctrl;
    ptr_load  = wr && hit_win && !data_mode;
    strobe_wr = wr && hit_win && data_mode;
    strobe_rd = rd_op && hit_win && data_mode;
    ptr_inc   = (strobe_wr && (fn == FN_DATA_INC || fn == FN_DATA_INCW))
             || (strobe_rd && fn == FN_DATA_INC);
    rd_take   = rd_op;

    if (hit_ctrl)                  rd_src = SRC_CTRL;
    else if (hit_win && data_mode) rd_src = SRC_DEV;
    else if (hit_win)              rd_src = SRC_PTR;
    else                           rd_src = SRC_ZERO;
  end
endmodule

// File: rtl/mmd_window_bridge.sv
module mmd_window_bridge
  import mmd_window_pkg::*;
#(
  parameter int REG_AW    = 5,
  parameter int DATA_W    = 16,
  parameter int DEV_AW    = 5,
  parameter int CTRL_ADDR = 13,
  parameter int WIN_ADDR  = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] mg_addr,
  input  logic              mg_wr,
  input  logic              mg_rd,
  input  logic [DATA_W-1:0] mg_wdata,
  output logic [DATA_W-1:0] mg_rdata,
  output logic [DATA_W-1:0] dev_addr,
  output logic [DEV_AW-1:0] dev_sel,
  output logic [DATA_W-1:0] dev_wdata,
  output logic              dev_wr,
  output logic              dev_rd,
  input  logic [DATA_W-1:0] dev_rdata
);
  localparam int FN_HI  = DATA_W - 1;
  localparam int PAD_W  = DATA_W - 2 - DEV_AW;

  win_fn_e           fn_q;
  logic [DEV_AW-1:0] dev_q;
  logic [DATA_W-1:0] ptr_cur;
  logic              ctrl_we, ptr_load, ptr_inc, rd_take;
  rd_src_e           rd_src;
  logic [DATA_W-1:0] ctrl_view, rd_mux;

  mmd_ctrl_reg #(.DEV_AW(DEV_AW)) u_ctrl (
    .clk(clk), .rst(rst), .we(ctrl_we),
    .fn_in(mg_wdata[FN_HI -: 2]), .dev_in(mg_wdata[DEV_AW-1:0]),
    .fn_q(fn_q), .dev_q(dev_q)
  );

  mmd_win_decode #(.REG_AW(REG_AW), .CTRL_ADDR(CTRL_ADDR), .WIN_ADDR(WIN_ADDR)) u_dec (
    .addr(mg_addr), .wr(mg_wr), .rd(mg_rd), .fn(fn_q),
    .ctrl_we(ctrl_we), .ptr_load(ptr_load), .ptr_inc(ptr_inc),
    .strobe_wr(dev_wr), .strobe_rd(dev_rd), .rd_take(rd_take), .rd_src(rd_src)
  );

  mmd_ptr_file #(.DEV_AW(DEV_AW), .PTR_W(DATA_W)) u_ptrs (
    .clk(clk), .rst(rst), .idx(dev_q), .load(ptr_load), .load_val(mg_wdata),
    .inc(ptr_inc), .cur(ptr_cur)
  );

  assign dev_addr  = ptr_cur;
  assign dev_sel   = dev_q;
  assign dev_wdata = mg_wdata;
  assign ctrl_view = {fn_q, {PAD_W{1'b0}}, dev_q};

  always_comb begin
    unique case (rd_src)
      SRC_CTRL: rd_mux = ctrl_view;
      SRC_PTR:  rd_mux = ptr_cur;
      SRC_DEV:  rd_mux = dev_rdata;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          mg_rdata <= '0;
    else if (rd_take) mg_rdata <= rd_mux;
  end

  logic win_hit, other_hit;
  assign win_hit   = (mg_addr == REG_AW'(WIN_ADDR));
  assign other_hit = !win_hit && (mg_addr != REG_AW'(CTRL_ADDR));

  a_r9_single_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dev_wr, dev_rd}));

  a_r9_strobe_needs_access: assert property (@(posedge clk) disable iff (rst)
    (dev_wr || dev_rd) |-> (win_hit && (mg_wr || mg_rd)));

  a_r3_ptr_mode_quiet: assert property (@(posedge clk) disable iff (rst)
    (fn_q == FN_PTR) |-> !(dev_wr || dev_rd));

  a_r5_fixed_ptr_stays: assert property (@(posedge clk) disable iff (rst)
    (fn_q == FN_DATA && win_hit && (mg_wr || mg_rd)) |=> $stable(dev_addr));

  a_r7_read_keeps_ptr: assert property (@(posedge clk) disable iff (rst)
    (fn_q == FN_DATA_INCW && dev_rd) |=> $stable(dev_addr));

  a_r10_other_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (mg_rd && !mg_wr && other_hit) |=> (mg_rdata == '0));

  a_r10_other_no_effect: assert property (@(posedge clk) disable iff (rst)
    ((mg_wr || mg_rd) && other_hit) |=> ($stable(dev_addr) && $stable(dev_sel)));

  a_r11_rdata_held: assert property (@(posedge clk) disable iff (rst)
    !(mg_rd && !mg_wr) |=> $stable(mg_rdata));
endmodule

// File: tb/tb_mmd_window_bridge.sv
module tb_mmd_window_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int NDEV = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  mg_addr = '0;
  logic        mg_wr = 1'b0, mg_rd = 1'b0;
  logic [15:0] mg_wdata = '0;
  logic [15:0] mg_rdata, dev_addr, dev_wdata, dev_rdata;
  logic [4:0]  dev_sel;
  logic        dev_wr, dev_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmd_window_bridge dut (
    .clk(clk), .rst(rst), .mg_addr(mg_addr), .mg_wr(mg_wr), .mg_rd(mg_rd),
    .mg_wdata(mg_wdata), .mg_rdata(mg_rdata), .dev_addr(dev_addr),
    .dev_sel(dev_sel), .dev_wdata(dev_wdata), .dev_wr(dev_wr), .dev_rd(dev_rd),
    .dev_rdata(dev_rdata)
  );

  function automatic logic [15:0] dev_model(input logic [15:0] a, input logic [4:0] d);
    return a ^ {d, 11'h2a5};
  endfunction
  assign dev_rdata = dev_model(dev_addr, dev_sel);

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] m_ptr [NDEV];
  logic [1:0]  m_fn;
  logic [4:0]  m_dev;
  logic [15:0] m_rdata;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // One management access with full model update and checks.
  task automatic access(input logic wr, input logic rd, input logic [4:0] a, input logic [15:0] d);
    logic data_mode, rd_op, exp_wr, exp_rd;
    logic [15:0] exp_r;
    data_mode = (m_fn != 2'd0);
    rd_op     = rd && !wr;
    exp_wr    = wr && a == 5'd14 && data_mode;
    exp_rd    = rd_op && a == 5'd14 && data_mode;
    @(negedge clk);
    mg_wr = wr; mg_rd = rd; mg_addr = a; mg_wdata = d;
    #1;
    check("R9 write strobe", dev_wr, exp_wr);
    check("R9 read strobe", dev_rd, exp_rd);
    if (exp_wr || exp_rd) begin
      check("R5 device", dev_sel, m_dev);
      check("R5 address", dev_addr, m_ptr[m_dev]);
      if (exp_wr) check("R5 write data", dev_wdata, d);
    end
    if (a == 5'd13) exp_r = {m_fn, 9'd0, m_dev};
    else if (a == 5'd14 && data_mode) exp_r = dev_model(m_ptr[m_dev], m_dev);
    else if (a == 5'd14) exp_r = m_ptr[m_dev];
    else exp_r = 16'h0000;
    if (rd_op) m_rdata = exp_r;
    if (wr && a == 5'd13) begin m_fn = d[15:14]; m_dev = d[4:0]; end
    if (wr && a == 5'd14 && !data_mode) m_ptr[m_dev] = d;
    if (exp_wr && m_fn[1]) m_ptr[m_dev] = m_ptr[m_dev] + 16'd1;
    if (exp_rd && m_fn == 2'd2) m_ptr[m_dev] = m_ptr[m_dev] + 16'd1;
    @(negedge clk);
    mg_wr = 0; mg_rd = 0;
    check("R11 read data", mg_rdata, m_rdata);
  endtask

  task automatic read_ptr(input logic [4:0] dv, input string req);
    access(1, 0, 5'd13, {2'd0, 9'd0, dv});
    access(0, 1, 5'd14, 16'h0);
    check(req, mg_rdata, m_ptr[dv]);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7331));
    for (int i = 0; i < NDEV; i++) m_ptr[i] = 16'h0;
    m_fn = 2'd0; m_dev = 5'd0; m_rdata = 16'h0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    access(0, 1, 5'd13, 16'h0);
    check("R1 ctrl reset", mg_rdata, 16'h0000);
    read_ptr(5'd19, "R1 pointer reset");
    // R2 reserved bits
    access(1, 0, 5'd13, 16'hffe3);
    access(0, 1, 5'd13, 16'h0);
    check("R2 reserved zero", mg_rdata, 16'hc003);
    // R3 load and read back, R4 per-device independence
    for (int dv = 0; dv < NDEV; dv++) begin
      access(1, 0, 5'd13, {2'd0, 9'd0, 5'(dv)});
      access(1, 0, 5'd14, 16'h1000 + 16'(dv * 37));
    end
    for (int dv = 0; dv < NDEV; dv++) read_ptr(5'(dv), "R4 pointer per device");
    // R5 fixed pointer
    access(1, 0, 5'd13, {2'd1, 9'd0, 5'd4});
    access(1, 0, 5'd14, 16'hbeef);
    access(0, 1, 5'd14, 16'h0);
    read_ptr(5'd4, "R5 pointer unchanged");
    // R6 increment on read and write
    access(1, 0, 5'd13, {2'd2, 9'd0, 5'd6});
    access(0, 1, 5'd14, 16'h0);
    access(1, 0, 5'd14, 16'h1234);
    read_ptr(5'd6, "R6 advance read and write");
    // R7 increment on write only
    access(1, 0, 5'd13, {2'd3, 9'd0, 5'd7});
    access(0, 1, 5'd14, 16'h0);
    access(0, 1, 5'd14, 16'h0);
    access(1, 0, 5'd14, 16'h5555);
    read_ptr(5'd7, "R7 write-only advance");
    // R8 wrap
    access(1, 0, 5'd14, 16'hffff);
    access(1, 0, 5'd13, {2'd2, 9'd0, 5'd7});
    access(0, 1, 5'd14, 16'h0);
    read_ptr(5'd7, "R8 wrap to zero");
    check("R8 wrap value", mg_rdata, 16'h0000);
    // R10 other address
    access(1, 0, 5'd3, 16'hffff);
    access(0, 1, 5'd3, 16'h0);
    check("R10 other reads zero", mg_rdata, 16'h0000);
    access(0, 1, 5'd13, 16'h0);
    check("R10 ctrl untouched", mg_rdata, 16'h0007);
    // R11 simultaneous read and write: write only
    access(1, 1, 5'd13, {2'd1, 9'd0, 5'd9});
    access(0, 1, 5'd13, 16'h0);
    check("R11 write wins", mg_rdata, 16'h4009);
    // random mix
    for (int k = 0; k < 600; k++) begin
      int sel;
      logic [4:0] a;
      logic [15:0] d;
      logic w, r;
      sel = $urandom_range(0, 9);
      a = (sel < 3) ? 5'd13 : (sel < 8) ? 5'd14 : 5'($urandom_range(0, 31));
      d = 16'($urandom);
      if (a == 5'd13) d[4:0] = 5'($urandom_range(0, 3));
      w = 1'($urandom_range(0, 1));
      r = (!w) ? 1'b1 : (($urandom_range(0, 9) == 0) ? 1'b1 : 1'b0);
      access(w, r, a, d);
    end
    for (int dv = 0; dv < 4; dv++) read_ptr(5'(dv), "R6 R7 random pointers");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule